// File: doc/BRIEF.md
# Incremental Ternary Gate Evaluator

This block works out the output of one basic logic gate whose inputs take three values: logic zero, logic one and unknown. It serves as the evaluation core of a hardware logic simulator. The gate type and the number of inputs in use are set while the block is held in reset. From then on the result is produced each cycle in one of two ways.

In scan mode every in-use input on the parallel input bus is examined in the same cycle. In count mode the block holds three tallies: in-use inputs at zero, at one, and at unknown. Each input-change event carries an input index, the value that input had before and the value it has now. The event moves one unit from the old value's tally to the new value's tally. The result then comes from the tallies alone, so no input is scanned again.

Both modes use the same three rules. Each gate type has a controlling value and an inversion flag. If any in-use input sits at the controlling value, the output is the controlling value XOR the inversion flag. Failing that, if any in-use input is unknown, the output is unknown. Otherwise the output is the non-controlling value XOR the inversion flag. The result is registered. A one-cycle flag marks each cycle in which the result differs from the cycle before.

Top module: `tern_gate_eval`

## Requirements
- R1: Values are 2-bit codes: 00 is zero, 11 is one and 01 is unknown. An input code of 10, on the bus or in an event, is read as unknown. The output never carries 10.
- R2: The gate code selects the controlling value c and the inversion flag i. 0 is AND (c=0, i=0), 1 is NAND (c=0, i=1), 2 is OR (c=1, i=0), 3 is NOR (c=1, i=1), 4 is BUF and 5 is NOT. BUF and NOT act as one-input AND and NAND on input 0. Codes 6 and 7 act as BUF.
- R3: If any in-use input equals c, the output is c XOR i.
- R4: If no in-use input equals c and at least one is unknown, the output is unknown.
- R5: If every in-use input is at the non-controlling value, the output is (NOT c) XOR i.
- R6: The inputs in use are indices 0 to F-1. F is the fan-in count, read as 1 when it is 0 and as the parameter N_IN when it is above N_IN. Inputs and events at other indices have no effect on the output.
- R7: In count mode, the output after a clock edge reflects every event accepted up to and including that edge. An accepted event takes one from the tally of its old value and adds one to the tally of its new value, so the three tallies always sum to F.
- R8: An event whose old and new values are equal after the mapping of R1 leaves the tallies unchanged.
- R9: A synchronous reset makes the output unknown and clears the change flag. It loads the tallies as F unknown inputs and no inputs at zero or one. The gate code and the fan-in count change only while reset is asserted.
- R10: out_chg is high in exactly those cycles in which out_val differs from its value one cycle earlier, reset excepted.
- R11: The tallies follow events in both modes. After any stretch of events, count mode gives the same result that scan mode gives for the matching input values.
- R12: In scan mode, the output after a clock edge reflects the input bus sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 selects scan, 1 selects count |
| gate | input | 3 | Gate type code |
| fanin | input | CW | Number of inputs in use |
| in_vec | input | 2*N_IN | Ternary inputs, input k at bits 2k+1:2k |
| ev_valid | input | 1 | An input-change event is present this cycle |
| ev_idx | input | IW | Index of the changed input |
| ev_old | input | 2 | Value of that input before the change |
| ev_new | input | 2 | Value of that input after the change |
| out_val | output | 2 | Registered ternary result |
| out_chg | output | 1 | Result changed in this cycle |

## Verification
The bench uses N_IN = 8. That gives a 3-bit event index and 4-bit tallies, so every index can be addressed. It also lets fan-in counts of 0, below the limit, at the limit and above the limit all be driven, which exercises the clamping of R6 and tallies that reach their full count. The reference model rebuilds input values from events and scans them each cycle. This makes the random event runs, with mode switches between them, a direct comparison of count-mode results against scan-mode results for every gate type.

// File: rtl/tern_pkg.sv
package tern_pkg;

  typedef logic [1:0] tern_t;

  localparam tern_t T_ZERO = 2'b00;
  localparam tern_t T_ONE  = 2'b11;
  localparam tern_t T_UNK  = 2'b01;

  localparam logic [2:0] G_AND  = 3'd0;
  localparam logic [2:0] G_NAND = 3'd1;
  localparam logic [2:0] G_OR   = 3'd2;
  localparam logic [2:0] G_NOR  = 3'd3;
  localparam logic [2:0] G_BUF  = 3'd4;
  localparam logic [2:0] G_NOT  = 3'd5;

  // Map the illegal code onto unknown.
  function automatic tern_t t_norm(tern_t v);
    return (v == T_ZERO || v == T_ONE) ? v : T_UNK;
  endfunction

  function automatic logic ctrl_of(logic [2:0] g);
    return (g == G_OR) || (g == G_NOR);
  endfunction

  function automatic logic inv_of(logic [2:0] g);
    return (g == G_NAND) || (g == G_NOR) || (g == G_NOT);
  endfunction

  function automatic tern_t resolve(logic has_c, logic has_u, logic c, logic i);
    tern_t r;
    if (has_c)      r = {2{c ^ i}};
    else if (has_u) r = T_UNK;
    else            r = {2{(~c) ^ i}};
    return r;
  endfunction

endpackage

// File: rtl/tern_scan.sv
module tern_scan
  import tern_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int CW   = $clog2(N_IN + 1)
) (
  input  logic [2*N_IN-1:0] in_vec,
  input  logic [CW-1:0]     eff,
  input  logic              ctrl,
  output logic              has_c,
  output logic              has_u
);

  logic [N_IN-1:0] hit_c;
  logic [N_IN-1:0] hit_u;

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    tern_t v;
    logic  used;
    assign v        = t_norm(in_vec[2*k +: 2]);
    assign used     = (k < int'(eff));
    assign hit_c[k] = used && (v == {2{ctrl}});
    assign hit_u[k] = used && (v == T_UNK);
  end

  assign has_c = |hit_c;
  assign has_u = |hit_u;

endmodule

// File: rtl/tern_tally.sv
module tern_tally
  import tern_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int IW   = $clog2(N_IN),
  parameter int CW   = $clog2(N_IN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] eff,
  input  logic          ev_valid,
  input  logic [IW-1:0] ev_idx,
  input  tern_t         ev_old,
  input  tern_t         ev_new,
  output logic [CW-1:0] n_z,
  output logic [CW-1:0] n_o,
  output logic [CW-1:0] n_u,
  output logic [CW-1:0] q_z,
  output logic [CW-1:0] q_o,
  output logic [CW-1:0] q_u
);

  tern_t ov, nv;
  logic  hit;

  assign ov  = t_norm(ev_old);
  assign nv  = t_norm(ev_new);
  assign hit = ev_valid && (CW'(ev_idx) < eff) && (ov != nv);

  always_comb begin
    n_z = q_z;
    n_o = q_o;
    n_u = q_u;
    if (hit) begin
      case (ov)
        T_ZERO:  n_z = n_z - CW'(1);
        T_ONE:   n_o = n_o - CW'(1);
        default: n_u = n_u - CW'(1);
      endcase
      case (nv)
        T_ZERO:  n_z = n_z + CW'(1);
        T_ONE:   n_o = n_o + CW'(1);
        default: n_u = n_u + CW'(1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_z <= '0;
      q_o <= '0;
      q_u <= eff;
    end else begin
      q_z <= n_z;
      q_o <= n_o;
      q_u <= n_u;
    end
  end

endmodule

// File: rtl/tern_gate_eval.sv
module tern_gate_eval
  import tern_pkg::*;
#(
  parameter int N_IN = 8,
  localparam int IW  = $clog2(N_IN),
  localparam int CW  = $clog2(N_IN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic [2:0]        gate,
  input  logic [CW-1:0]     fanin,
  input  logic [2*N_IN-1:0] in_vec,
  input  logic              ev_valid,
  input  logic [IW-1:0]     ev_idx,
  input  logic [1:0]        ev_old,
  input  logic [1:0]        ev_new,
  output logic [1:0]        out_val,
  output logic              out_chg
);

  logic [CW-1:0] eff;
  logic          ctrl, inv;
  logic          s_has_c, s_has_u;
  logic [CW-1:0] n_z, n_o, n_u;
  logic [CW-1:0] q_z, q_o, q_u;
  logic [CW-1:0] n_c;
  tern_t         nxt;
  tern_t         out_q;
  logic          chg_q;

  always_comb begin
    if (gate >= G_BUF)                eff = CW'(1);
    else if (fanin == '0)             eff = CW'(1);
    else if (fanin > CW'(N_IN))       eff = CW'(N_IN);
    else                              eff = fanin;
  end

  assign ctrl = ctrl_of(gate);
  assign inv  = inv_of(gate);

  tern_scan #(.N_IN(N_IN), .CW(CW)) u_scan (
    .in_vec (in_vec),
    .eff    (eff),
    .ctrl   (ctrl),
    .has_c  (s_has_c),
    .has_u  (s_has_u)
  );

  tern_tally #(.N_IN(N_IN), .IW(IW), .CW(CW)) u_tally (
    .clk      (clk),
    .rst      (rst),
    .eff      (eff),
    .ev_valid (ev_valid),
    .ev_idx   (ev_idx),
    .ev_old   (ev_old),
    .ev_new   (ev_new),
    .n_z      (n_z),
    .n_o      (n_o),
    .n_u      (n_u),
    .q_z      (q_z),
    .q_o      (q_o),
    .q_u      (q_u)
  );

  assign n_c = ctrl ? n_o : n_z;

  always_comb begin
    if (mode) nxt = resolve(n_c != '0, n_u != '0, ctrl, inv);
    else      nxt = resolve(s_has_c, s_has_u, ctrl, inv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= T_UNK;
      chg_q <= 1'b0;
    end else begin
      out_q <= nxt;
      chg_q <= (nxt != out_q);
    end
  end

  assign out_val = out_q;
  assign out_chg = chg_q;

endmodule

// File: rtl/tern_gate_eval_chk.sv
module tern_gate_eval_chk #(
  parameter int N_IN = 8,
  parameter int CW   = $clog2(N_IN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    out_val,
  input logic          out_chg,
  input logic [CW-1:0] q_z,
  input logic [CW-1:0] q_o,
  input logic [CW-1:0] q_u,
  input logic [CW-1:0] eff
);

  AST_OUT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_val != 2'b10); // R1

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_val == 2'b01 && !out_chg)); // R9

  AST_CHG_MEANS_MOVE: assert property (@(posedge clk) disable iff (rst)
    out_chg |-> (out_val != $past(out_val))); // R10

  AST_MOVE_MEANS_CHG: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_val != $past(out_val)) |-> out_chg); // R10

  AST_TALLY_SUM: assert property (@(posedge clk) disable iff (rst)
    (int'(q_z) + int'(q_o) + int'(q_u)) == int'(eff)); // R7

endmodule

bind tern_gate_eval tern_gate_eval_chk #(.N_IN(N_IN), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .out_val (out_val),
  .out_chg (out_chg),
  .q_z     (q_z),
  .q_o     (q_o),
  .q_u     (q_u),
  .eff     (eff)
);

// File: tb/tb_tern_gate_eval.sv
`timescale 1ns/100ps
module tb_tern_gate_eval;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           mode = 1'b0;
  logic [2:0]     gate = 3'd0;
  logic [3:0]     fanin = 4'd8;
  logic [2*N-1:0] in_vec = {N{2'b01}};
  logic           ev_valid = 1'b0;
  logic [2:0]     ev_idx = 3'd0;
  logic [1:0]     ev_old = 2'b01;
  logic [1:0]     ev_new = 2'b01;
  logic [1:0]     out_val;
  logic           out_chg;

  tern_gate_eval #(.N_IN(N)) dut (
    .clk(clk), .rst(rst), .mode(mode), .gate(gate), .fanin(fanin),
    .in_vec(in_vec), .ev_valid(ev_valid), .ev_idx(ev_idx),
    .ev_old(ev_old), .ev_new(ev_new), .out_val(out_val), .out_chg(out_chg)
  );

  always #2.5 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string req     = "R9";
  int    ref_cur [N];
  int    exp_out = 2;
  bit    exp_chg = 0;

  // ternary as int: 0, 1, 2 = unknown
  function automatic int tv(logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b11) return 1;
    return 2;
  endfunction

  function automatic logic [1:0] code(int t);
    if (t == 0) return 2'b00;
    if (t == 1) return 2'b11;
    return 2'b01;
  endfunction

  function automatic int eff_of();
    if (gate >= 3'd4) return 1;
    if (fanin == 4'd0) return 1;
    if (int'(fanin) > N) return N;
    return int'(fanin);
  endfunction

  function automatic int rule(bit hc, bit hu, int g);
    int c, i;
    c = (g == 2 || g == 3) ? 1 : 0;
    i = (g == 1 || g == 3 || g == 5) ? 1 : 0;
    if (hc) return c ^ i;
    if (hu) return 2;
    return (1 - c) ^ i;
  endfunction

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < N; k++) ref_cur[k] = 2;
      exp_out = 2;
      exp_chg = 0;
    end else begin
      int  e, g, c, v, nv;
      bit  hc, hu;
      e = eff_of();
      g = (gate > 3'd5) ? 4 : int'(gate);
      c = (g == 2 || g == 3) ? 1 : 0;
      if (ev_valid && int'(ev_idx) < e && tv(ev_old) != tv(ev_new))
        ref_cur[ev_idx] = tv(ev_new);
      hc = 0; hu = 0;
      for (int k = 0; k < e; k++) begin
        v = mode ? ref_cur[k] : tv(in_vec[2*k +: 2]);
        if (v == c) hc = 1;
        if (v == 2) hu = 1;
      end
      nv = rule(hc, hu, g);
      exp_chg = (nv != exp_out);
      exp_out = nv;
    end
    #1;
    n_tests++;
    if (out_val !== code(exp_out) || out_chg !== exp_chg) begin
      n_fail++;
      $display("FAIL %s: out_val=%b out_chg=%b expected out_val=%b out_chg=%b",
               req, out_val, out_chg, code(exp_out), exp_chg);
    end
    @(negedge clk);
  endtask

  task automatic do_reset(logic [2:0] g, logic [3:0] f);
    gate = g; fanin = f; rst = 1'b1; ev_valid = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic set_all(int t);
    for (int k = 0; k < N; k++) in_vec[2*k +: 2] = code(t);
  endtask

  task automatic set_in(int k, logic [1:0] c);
    in_vec[2*k +: 2] = c;
  endtask

  task automatic sync_vec();
    for (int k = 0; k < N; k++) in_vec[2*k +: 2] = code(ref_cur[k]);
  endtask

  task automatic ev(int k, int t);
    ev_valid = 1'b1; ev_idx = 3'(k);
    ev_old = code(ref_cur[k]); ev_new = code(t);
    tick();
    ev_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    req = "R9";
    tick(); tick(); tick();
    rst = 1'b0;
    tick();

    // scan mode, AND over 8 inputs; R12 timing throughout
    req = "R5"; set_all(1); tick(); tick();
    req = "R3"; set_in(3, 2'b00); tick();
    req = "R4"; set_in(3, 2'b01); tick();
    req = "R1"; set_in(3, 2'b10); tick();
    set_all(1); tick(); set_in(6, 2'b10); tick();
    req = "R12"; set_all(0); tick(); set_all(1); tick();

    // R2: every gate code over several patterns
    req = "R2";
    for (int g = 0; g < 8; g++) begin
      do_reset(3'(g), 4'd8);
      set_all(0); tick();
      set_all(1); tick();
      set_all(1); set_in(2, 2'b00); tick();
      set_all(1); set_in(5, 2'b01); tick();
      set_all(0); set_in(1, 2'b01); tick();
      set_all(2); tick();
      set_all(1); set_in(0, 2'b00); tick();
      set_all(0); set_in(0, 2'b11); tick();
      set_all(0); set_in(0, 2'b10); tick();
    end

    // R6: fan-in limits in scan mode
    req = "R6";
    do_reset(3'd0, 4'd3);
    set_all(1); tick();
    set_in(5, 2'b00); tick();
    set_in(7, 2'b01); tick();
    set_in(2, 2'b00); tick();
    do_reset(3'd2, 4'd0);
    set_all(1); set_in(0, 2'b00); tick();
    do_reset(3'd2, 4'd12);
    set_all(0); set_in(7, 2'b11); tick();

    // R7: count mode, AND over 4 inputs
    req = "R7";
    mode = 1'b1;
    do_reset(3'd0, 4'd4);
    tick();
    ev(0, 1); ev(1, 1); ev(2, 1); ev(3, 1);
    tick();
    ev(2, 0); tick();
    req = "R6";
    ev(6, 0); tick();
    ev(2, 1); tick();
    ev(7, 0); tick();
    ev(2, 0);
    req = "R8";
    ev_valid = 1'b1; ev_idx = 3'd2; ev_old = 2'b11; ev_new = 2'b11; tick();
    ev_valid = 1'b1; ev_idx = 3'd1; ev_old = 2'b10; ev_new = 2'b01; tick();
    ev_valid = 1'b0;
    tick();
    req = "R7";
    ev(2, 1); tick();
    ev(1, 2); tick();
    ev(1, 1); tick();

    // R11: switch modes with matching input bus
    req = "R11";
    sync_vec(); mode = 1'b0; tick(); tick();
    mode = 1'b1; ev(3, 0); sync_vec(); mode = 1'b0; tick();
    mode = 1'b1; tick();

    // R11 / R10: random event runs compared against scan results
    for (int r = 0; r < 48; r++) begin
      req = "R11";
      do_reset(3'($urandom_range(0, 7)), 4'($urandom_range(0, 11)));
      mode = 1'($urandom_range(0, 1));
      sync_vec();
      for (int s = 0; s < 50; s++) begin
        int k, t;
        mode = 1'($urandom_range(0, 1));
        if (($urandom_range(0, 3)) != 0) begin
          k = int'($urandom_range(0, N - 1));
          t = int'($urandom_range(0, 2));
          ev(k, t);
        end else begin
          req = "R10";
          tick();
          req = "R11";
        end
        sync_vec();
      end
      mode = 1'b0; tick();
      mode = 1'b1; tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule